// File: doc/BRIEF.md
# Event Record Stream Decoder

This block sits between a memory reader and an event scheduler. The reader hands it wide words, each made of a parameterised number of bytes (64 by default, so 512 bits). Within a word, byte 0 sits in the lowest 8 bits. The bytes form a list of variable-length records. A record can begin at any byte position and can run across two or more words. The decoder keeps the bytes in a realigning buffer until a whole record is present. It then splits the record into its fields and presents one event on a valid/ready output.

Each record opens with a length byte that counts the whole record, the length byte included. Four little-endian fields follow, in a fixed order that the decoder depends on:

| Bytes | Field |
|-------|-------|
| 1 to 3 | channel |
| 4 to 11 | timestamp |
| 12 to 13 | register address |
| 14 onward | data, 1 to 64 bytes |

A length byte of zero closes the list. Software starts decoding by writing the run bit. The decoder clears that bit itself when the list ends or when it meets a malformed length, and it raises a done flag. If software clears the bit while a list is running, decoding stops and any partly buffered record is thrown away.

Top module: `dmarec_decoder`

## Requirements
- R1: For each well-formed record, the event carries the channel from record bytes 1..3, the timestamp from bytes 4..11 and the address from bytes 12..13, all least-significant byte first. The data comes from byte 14 onward, and `ev_data_len` equals the length byte minus 14 (range 1..64).
- R2: `ev_data` holds data byte i in bits [8i+7:8i], and every bit above `ev_data_len` bytes is zero.
- R3: Input word byte j is bits [8j+7:8j]. A record decodes correctly at any starting byte offset and across any number of word boundaries.
- R4: A length byte of 0 sets `done`, clears `busy` and drops `in_ready`. No further words are taken. `err` stays 0.
- R5: A length byte of 1 to 14, or above 78, sets `err` and `done`, clears `busy` and drops `in_ready`. The malformed record produces no event.
- R6: While `ev_valid` is 1 and `ev_ready` is 0, all event fields hold stable and `in_ready` is 0. No buffered byte is lost.
- R7: A write of 1 to the run bit (`run_wr`=1, `run_wdata`=1) while idle sets `busy` and clears `done` and `err`. `busy` shows the run bit.
- R8: A write of 0 to the run bit while a list is in progress clears `busy` and drops `in_ready`. Any partial record is discarded, so the next started list decodes from its own first byte.
- R9: After reset, `busy`, `done`, `err`, `ev_valid` and `in_ready` are all 0.
- R10: Events leave in list order, each record exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| run_wr | input | 1 | Software write strobe for the run bit |
| run_wdata | input | 1 | Value written to the run bit |
| busy | output | 1 | Current run bit |
| done | output | 1 | The list ended (normally or on error) |
| err | output | 1 | A malformed length byte stopped the list |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder accepts the input word |
| in_word | input | WORD_BYTES*8 | Packed input bytes, byte 0 lowest |
| ev_valid | output | 1 | Event valid |
| ev_ready | input | 1 | Downstream accepts the event |
| ev_channel | output | 24 | Event channel |
| ev_timestamp | output | 64 | Event timestamp |
| ev_addr | output | 16 | Event register address |
| ev_data | output | 512 | Event data, zero-extended |
| ev_data_len | output | 7 | Data byte count |

## Verification
The bench mixes record sizes so that records begin at many byte offsets and some span three words. A decoder that realigned bytes wrongly would put shifted channel or data values into the events. Full 64-byte payloads and 1-byte payloads are used, so a bad mask would leak stale bytes above `ev_data_len`.

A run with a stall every other cycle would catch fields that change, or words taken, while the output is blocked. A lost or repeated buffered byte would show up as a wrong later record.

Malformed lengths at both ends of the invalid range must raise `err` and produce no event. An abort after half a record, followed by a fresh list, catches a buffer that is not flushed, because the leftover bytes would corrupt the first new event.

// File: rtl/dmarec_pkg.sv
package dmarec_pkg;
  // record layout (byte offsets inside one record)
  localparam int CH_OFS         = 1;
  localparam int TS_OFS         = 4;
  localparam int AD_OFS         = 12;
  localparam int HDR_BYTES      = 14;
  localparam int MAX_DATA_BYTES = 64;
  localparam int MAX_REC_BYTES  = HDR_BYTES + MAX_DATA_BYTES;

  localparam int CH_W   = 24;
  localparam int TS_W   = 64;
  localparam int AD_W   = 16;
  localparam int DATA_W = MAX_DATA_BYTES * 8;
  localparam int DLEN_W = 7;

  typedef struct packed {
    logic [CH_W-1:0]   channel;
    logic [TS_W-1:0]   ts;
    logic [AD_W-1:0]   addr;
    logic [DLEN_W-1:0] dlen;
    logic [DATA_W-1:0] data;
  } event_t;
endpackage

// File: rtl/dmarec_byte_buf.sv
// Byte realignment buffer: the oldest byte is always at position 0.
// A pop removes a whole record from the front; a push appends one word
// behind the bytes that remain after the pop.
module dmarec_byte_buf #(
  parameter int WORD_BYTES = 64,
  parameter int BUF_BYTES  = 142,
  parameter int HEAD_BYTES = 78,
  parameter int FILL_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    push,
  input  logic [WORD_BYTES*8-1:0] word,
  input  logic                    pop,
  input  logic [7:0]              pop_len,
  output logic [HEAD_BYTES*8-1:0] head,
  output logic [FILL_W-1:0]       fill
);
  localparam int BUF_W = BUF_BYTES * 8;

  logic [BUF_W-1:0]  buf_q, buf_d, shifted;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              buf_ce;
  int                pl_i, base_i, src_i, off_i;

  // drop popped bytes from the front
  always_comb begin
    pl_i    = pop ? int'(pop_len) : 0;
    shifted = '0;
    src_i   = 0;
    for (int k = 0; k < BUF_BYTES; k++) begin
      src_i = k + pl_i;
      if (src_i < BUF_BYTES) shifted[k*8 +: 8] = buf_q[src_i*8 +: 8];
    end
  end

  // append the incoming word behind the remaining bytes
  always_comb begin
    base_i = int'(fill_q) - pl_i;
    buf_d  = shifted;
    off_i  = 0;
    for (int k = 0; k < BUF_BYTES; k++) begin
      off_i = k - base_i;
      if (push && off_i >= 0 && off_i < WORD_BYTES)
        buf_d[k*8 +: 8] = word[off_i*8 +: 8];
    end
  end

  always_comb begin
    if (flush) fill_d = '0;
    else       fill_d = FILL_W'(int'(fill_q) - pl_i + (push ? WORD_BYTES : 0));
    buf_ce = (push || pop) && !flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  always_ff @(posedge clk) begin
    if (buf_ce) buf_q <= buf_d;
  end

  assign head = buf_q[HEAD_BYTES*8-1:0];
  assign fill = fill_q;

  p_fill_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_q) <= BUF_BYTES);
  p_pop_whole_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> int'(fill_q) >= int'(pop_len));
  p_push_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(fill_q) + WORD_BYTES <= BUF_BYTES));
endmodule

// File: rtl/dmarec_extract.sv
// Splits the front record of the buffer into fields; masks data above its length.
module dmarec_extract
  import dmarec_pkg::*;
#(
  parameter int HEAD_BYTES = MAX_REC_BYTES
) (
  input  logic [HEAD_BYTES*8-1:0] head,
  output logic [7:0]              rec_len,
  output event_t                  fields
);
  logic [DLEN_W-1:0] dlen;

  assign rec_len        = head[7:0];
  assign dlen           = DLEN_W'(rec_len - 8'(HDR_BYTES));
  assign fields.channel = head[CH_OFS*8 +: CH_W];
  assign fields.ts      = head[TS_OFS*8 +: TS_W];
  assign fields.addr    = head[AD_OFS*8 +: AD_W];
  assign fields.dlen    = dlen;

  for (genvar b = 0; b < MAX_DATA_BYTES; b++) begin : g_mask
    assign fields.data[b*8 +: 8] =
      (DLEN_W'(b) < dlen) ? head[(HDR_BYTES+b)*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/dmarec_ctrl.sv
// Run bit, end/error detection, input flow control and the event register.
module dmarec_ctrl
  import dmarec_pkg::*;
#(
  parameter int WORD_BYTES = 64,
  parameter int BUF_BYTES  = 142,
  parameter int FILL_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_wr,
  input  logic              run_wdata,
  input  logic              in_valid,
  input  logic              ev_ready,
  input  logic [FILL_W-1:0] fill,
  input  logic [7:0]        rec_len,
  input  event_t            rec_fields,
  output logic              push,
  output logic              pop,
  output logic              flush,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ev_valid,
  output event_t            ev_q
);
  logic   run_q, run_d, done_q, done_d, err_q, err_d, evv_q, evv_d;
  logic   have_len, len_end, len_bad, rec_whole, finish;
  logic   start_wr, stop_wr, out_free, room;
  event_t ev_d;

  always_comb begin
    have_len  = fill != '0;
    len_end   = have_len && (rec_len == 8'd0);
    len_bad   = have_len && (((rec_len != 8'd0) && (rec_len <= 8'(HDR_BYTES)))
                             || (rec_len > 8'(MAX_REC_BYTES)));
    rec_whole = have_len && !len_end && !len_bad && (int'(fill) >= int'(rec_len));
    finish    = run_q && (len_end || len_bad);
    start_wr  = run_wr && run_wdata && !run_q;
    stop_wr   = run_wr && !run_wdata;
    out_free  = !evv_q || ev_ready;
    room      = (int'(fill) + WORD_BYTES) <= BUF_BYTES;

    flush     = finish || start_wr || stop_wr;
    pop       = run_q && !stop_wr && rec_whole && out_free;
    in_ready  = run_q && !finish && !stop_wr && out_free && room;
    push      = in_valid && in_ready;

    run_d  = run_wr ? run_wdata : (finish ? 1'b0 : run_q);
    done_d = start_wr ? 1'b0 : (finish ? 1'b1 : done_q);
    err_d  = start_wr ? 1'b0 : ((finish && len_bad) ? 1'b1 : err_q);
    evv_d  = pop ? 1'b1 : (ev_ready ? 1'b0 : evv_q);
    ev_d   = pop ? rec_fields : ev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      evv_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      err_q  <= err_d;
      evv_q  <= evv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) ev_q <= ev_d;
  end

  assign busy     = run_q;
  assign done     = done_q;
  assign err      = err_q;
  assign ev_valid = evv_q;

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evv_q && !ev_ready) |=> (evv_q && $stable(ev_q)));
  p_dlen_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evv_q |-> (ev_q.dlen >= 7'd1 && ev_q.dlen <= 7'(MAX_DATA_BYTES)));
  p_err_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);
  p_done_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (!run_q && !in_ready));
endmodule

// File: rtl/dmarec_decoder.sv
module dmarec_decoder
  import dmarec_pkg::*;
#(
  parameter int WORD_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_wr,
  input  logic                    run_wdata,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_BYTES*8-1:0] in_word,
  output logic                    ev_valid,
  input  logic                    ev_ready,
  output logic [23:0]             ev_channel,
  output logic [63:0]             ev_timestamp,
  output logic [15:0]             ev_addr,
  output logic [511:0]            ev_data,
  output logic [6:0]              ev_data_len
);
  localparam int BUF_BYTES = MAX_REC_BYTES + WORD_BYTES;
  localparam int FILL_W    = $clog2(BUF_BYTES + 1);

  logic                       push, pop, flush;
  logic [MAX_REC_BYTES*8-1:0] head;
  logic [FILL_W-1:0]          fill;
  logic [7:0]                 rec_len;
  event_t                     rec_fields, ev_q;

  dmarec_byte_buf #(
    .WORD_BYTES(WORD_BYTES), .BUF_BYTES(BUF_BYTES),
    .HEAD_BYTES(MAX_REC_BYTES), .FILL_W(FILL_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .word(in_word),
    .pop(pop), .pop_len(rec_len), .head(head), .fill(fill)
  );

  dmarec_extract #(.HEAD_BYTES(MAX_REC_BYTES)) u_ext (
    .head(head), .rec_len(rec_len), .fields(rec_fields)
  );

  dmarec_ctrl #(
    .WORD_BYTES(WORD_BYTES), .BUF_BYTES(BUF_BYTES), .FILL_W(FILL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_wr(run_wr), .run_wdata(run_wdata),
    .in_valid(in_valid), .ev_ready(ev_ready), .fill(fill), .rec_len(rec_len),
    .rec_fields(rec_fields), .push(push), .pop(pop), .flush(flush),
    .in_ready(in_ready), .busy(busy), .done(done), .err(err),
    .ev_valid(ev_valid), .ev_q(ev_q)
  );

  assign ev_channel   = ev_q.channel;
  assign ev_timestamp = ev_q.ts;
  assign ev_addr      = ev_q.addr;
  assign ev_data      = ev_q.data;
  assign ev_data_len  = ev_q.dlen;

  p_data_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ((ev_data >> (int'(ev_data_len) * 8)) == '0));
  p_idle_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
endmodule

// File: tb/tb_dmarec_decoder.sv
`timescale 1ns/1ps
module tb_dmarec_decoder;
  localparam int WB = 64;

  typedef struct packed {
    logic [23:0]  ch;
    logic [63:0]  ts;
    logic [15:0]  ad;
    logic [6:0]   dl;
    logic [511:0] dt;
  } exp_t;

  logic clk, rst_n, run_wr, run_wdata, busy, done, err;
  logic in_valid, in_ready, ev_valid, ev_ready;
  logic [WB*8-1:0] in_word;
  logic [23:0] ev_channel;
  logic [63:0] ev_timestamp;
  logic [15:0] ev_addr;
  logic [511:0] ev_data;
  logic [6:0] ev_data_len;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] stream[$];
  exp_t exp_q[$];

  dmarec_decoder #(.WORD_BYTES(WB)) dut (
    .clk(clk), .rst_n(rst_n), .run_wr(run_wr), .run_wdata(run_wdata),
    .busy(busy), .done(done), .err(err), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_channel(ev_channel), .ev_timestamp(ev_timestamp),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_data_len(ev_data_len)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [639:0] act, input logic [639:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic add_record(input logic [23:0] ch, input logic [63:0] ts,
                            input logic [15:0] ad, input int dlen, input int seed);
    exp_t e;
    e = '0;
    e.ch = ch; e.ts = ts; e.ad = ad; e.dl = 7'(dlen);
    stream.push_back(8'(14 + dlen));
    for (int i = 0; i < 3; i++) stream.push_back(ch[i*8 +: 8]);
    for (int i = 0; i < 8; i++) stream.push_back(ts[i*8 +: 8]);
    for (int i = 0; i < 2; i++) stream.push_back(ad[i*8 +: 8]);
    for (int i = 0; i < dlen; i++) begin
      e.dt[i*8 +: 8] = 8'(seed * 29 + i * 13 + 7);
      stream.push_back(e.dt[i*8 +: 8]);
    end
    exp_q.push_back(e);
  endtask

  task automatic write_run(input logic v);
    @(negedge clk);
    run_wr = 1'b1; run_wdata = v;
    @(negedge clk);
    run_wr = 1'b0;
  endtask

  // feed words from the stream; stops at max_words or when decoder halts
  task automatic push_words(input int max_words);
    int idx = 0;
    int sent = 0;
    while (idx < stream.size() && sent < max_words) begin
      @(negedge clk);
      for (int b = 0; b < WB; b++)
        in_word[b*8 +: 8] = (idx + b < stream.size()) ? stream[idx + b] : 8'h00;
      in_valid = 1'b1;
      #1;
      if (!busy) break;
      if (in_ready) begin
        idx += WB;
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // accept events, compare in order; mode 1 stalls every other cycle
  task automatic drain(input int mode, input string req);
    bit held = 0;
    logic [639:0] hv = '0;
    int n = 0;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      ev_ready = (mode == 1) ? t[0] : 1'b1;
      #1;
      if (held) begin
        chk(ev_valid && ({ev_channel, ev_timestamp, ev_addr, ev_data_len, ev_data} == hv[622:0]),
            "R6", "fields held during stall",
            {17'd0, ev_channel, ev_timestamp, ev_addr, ev_data_len, ev_data}, hv);
      end
      held = 0;
      if (ev_valid && !ev_ready) begin
        held = 1;
        hv = {17'd0, ev_channel, ev_timestamp, ev_addr, ev_data_len, ev_data};
        chk(!in_ready, "R6", "in_ready low while stalled", 640'(in_ready), 640'(0));
      end
      if (ev_valid && ev_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected extra event", 640'(ev_channel), 640'(0));
        end else begin
          exp_t e = exp_q.pop_front();
          chk({ev_channel, ev_timestamp, ev_addr, ev_data_len, ev_data} == e,
              req, $sformatf("event %0d fields", n),
              {17'd0, ev_channel, ev_timestamp, ev_addr, ev_data_len, ev_data},
              {17'd0, e});
          n++;
        end
      end
      if (done && exp_q.size() == 0 && !ev_valid) break;
    end
    chk(exp_q.size() == 0, "R10", "all expected events seen", 640'(exp_q.size()), 640'(0));
    exp_q.delete();
    ev_ready = 1'b1;
  endtask

  task automatic run_list(input int mode, input string req);
    write_run(1'b1);
    fork
      push_words(1000);
      drain(mode, req);
    join
  endtask

  task automatic check_end(input logic exp_err, input string req);
    #1;
    chk(done == 1'b1, req, "done", 640'(done), 640'(1));
    chk(busy == 1'b0, req, "busy cleared", 640'(busy), 640'(0));
    chk(in_ready == 1'b0, req, "no more words", 640'(in_ready), 640'(0));
    chk(err == exp_err, req, "err", 640'(err), 640'(exp_err));
  endtask

  task automatic t_reset;
    #1;
    chk(!busy && !done && !err && !ev_valid && !in_ready, "R9", "reset state",
        640'({busy, done, err, ev_valid, in_ready}), 640'(0));
  endtask

  task automatic t_basic;
    stream.delete();
    add_record(24'h000001, 64'h23, 16'h0012, 1, 1);
    add_record(24'h000901, 64'h902, 16'h0911, 64, 2);
    add_record(24'h000081, 64'h288, 16'h0088, 2, 3);
    add_record(24'hABCDEF, 64'h0123456789ABCDEF, 16'hBEEF, 37, 4);
    stream.push_back(8'h00);
    run_list(0, "R1 R2 R3");
    check_end(1'b0, "R4");
  endtask

  task automatic t_stall;
    stream.delete();
    for (int r = 0; r < 12; r++)
      add_record(24'(r * 7919), 64'(r) << (r * 4), 16'(r * 257), (r * 23) % 64 + 1, r + 10);
    stream.push_back(8'h00);
    run_list(1, "R6 R10");
    check_end(1'b0, "R4");
  endtask

  task automatic t_malformed(input logic [7:0] badlen);
    stream.delete();
    add_record(24'h111111, 64'h2222, 16'h3333, 3, 20);
    stream.push_back(badlen);
    for (int i = 0; i < 90; i++) stream.push_back(8'h5A);
    run_list(0, "R5");
    check_end(1'b1, "R5");
    write_run(1'b1);
    #1;
    chk(busy && !done && !err, "R7", "start clears done and err",
        640'({busy, done, err}), 640'(3'b100));
    write_run(1'b0);
  endtask

  task automatic t_abort;
    stream.delete();
    add_record(24'h0F0F0F, 64'h77, 16'h0001, 64, 30);
    stream.push_back(8'h00);
    exp_q.delete();
    write_run(1'b1);
    ev_ready = 1'b1;
    push_words(1);
    repeat (4) @(negedge clk);
    #1;
    chk(!ev_valid && busy, "R8", "partial record not emitted",
        640'({ev_valid, busy}), 640'(2'b01));
    write_run(1'b0);
    #1;
    chk(!busy && !in_ready && !done, "R8", "abort stops intake",
        640'({busy, in_ready, done}), 640'(0));
    stream.delete();
    add_record(24'h00C0DE, 64'hFEED, 16'h0042, 5, 31);
    add_record(24'h00C0DF, 64'hFEEE, 16'h0043, 60, 32);
    stream.push_back(8'h00);
    run_list(0, "R8");
    check_end(1'b0, "R8");
  endtask

  initial begin
    rst_n = 1'b0; run_wr = 1'b0; run_wdata = 1'b0;
    in_valid = 1'b0; in_word = '0; ev_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_malformed(8'd5);
    t_malformed(8'd200);
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule